// File: doc/BRIEF.md
# Headset Microphone Bias Power-Up Sequencer

This block controls the start-up of a headset microphone bias supply. It holds two settings. The first is a two-bit ramp-rate code that chooses how fast the bias output slews. The second is a single bit that switches a pulldown onto the bias output. A level-sensitive power-up request starts a settle timer. The length of that timer depends on the ramp code: 10, 40, 90 or 170 milliseconds.

While the timer runs, the block reports itself busy and locks the ramp code. A write that tries to change the code during this time is dropped and recorded in a sticky flag, which software clears with a read strobe. When the timer expires, the block raises a status-valid flag. This flag tells downstream headset-detect logic that its comparator outputs can now be trusted. Releasing the request at any point aborts the timer, drops status-valid and unlocks the code.

The timer advances only on cycles where a tick-enable input is high. The parameter `TICKS_PER_MS` sets how many ticks make one millisecond, so the same logic works with a real millisecond strobe or with a scaled-down tick in simulation.

Top module: `bias_seq_top`

## Requirements
- R1: After a synchronous active-high reset the outputs are as follows: ramp code 2'b10 (slow), pulldown off, busy low, status-valid low and write-rejected low.
- R2: A write updates the pulldown bit on the next cycle at all times, even while busy. 1 means pulldown on.
- R3: When busy is low, a write loads the ramp code on the next cycle. The codes are 2'b00 fast rise with load-dependent fall, 2'b01 fast, 2'b10 slow and 2'b11 slowest.
- R4: After the request is sampled high from idle, busy stays high for exactly D×TICKS_PER_MS tick pulses. D is 10, 40, 90 or 170 for ramp codes 00, 01, 10 and 11.
- R5: The settle timer advances only on cycles with tick_en high. Cycles without a tick do not shorten the delay.
- R6: While busy is high, a write does not change the ramp code, and it sets write-rejected on the next cycle.
- R7: A read strobe clears write-rejected on the next cycle. If a rejected write happens in the same cycle as the read strobe, the flag stays set.
- R8: Status-valid rises only on the cycle after busy ends with the request still held. It then stays high while the request is held. Busy and status-valid are never high together.
- R9: If the request is sampled low, busy and status-valid are both low on the next cycle, and the ramp code accepts writes again.
- R10: Asserting reset during a ramp returns every output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advance strobe |
| pwr_req | input | 1 | Bias power-up request (level) |
| cfg_wr | input | 1 | Write strobe for the settings |
| cfg_ramp | input | 2 | Ramp code to write |
| cfg_pd | input | 1 | Pulldown bit to write |
| rej_rd | input | 1 | Read strobe that clears write-rejected |
| ramp_code | output | 2 | Applied ramp code |
| pd_on | output | 1 | Pulldown enable |
| busy | output | 1 | Settle timer running, ramp code locked |
| status_valid | output | 1 | Detect status may be trusted |
| wr_rejected | output | 1 | Sticky flag: a ramp write was dropped |

## Verification
The hardest case to reach from the ports is the collision inside the lock window. Here a rejected write and the clearing read strobe arrive in the same cycle, in the middle of a long ramp, and at the same time the pulldown bit in that same write must still be applied. The bench holds the request at the slow code and waits several cycles into the ramp. It then issues a write alone, then a read alone, then a write and read together, and checks the flag and both fields after each step. The timer length is swept over all four codes with a tick every cycle. The 40 ms code is then rerun with a sparse tick, counting the ticks delivered while busy.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  typedef enum logic [1:0] {
    RAMP_FAST_LD = 2'b00,
    RAMP_FAST    = 2'b01,
    RAMP_SLOW    = 2'b10,
    RAMP_SLOWEST = 2'b11
  } ramp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RAMP = 2'b01,
    ST_DONE = 2'b10
  } seq_state_e;

  localparam logic [1:0] RAMP_RESET = RAMP_SLOW;
  localparam int unsigned MAX_MS = 170;

  // settle delay in milliseconds for each ramp code
  function automatic int unsigned ramp_ms(input logic [1:0] code);
    case (code)
      RAMP_FAST_LD: ramp_ms = 10;
      RAMP_FAST:    ramp_ms = 40;
      RAMP_SLOW:    ramp_ms = 90;
      default:      ramp_ms = MAX_MS;
    endcase
  endfunction

endpackage

// File: rtl/bias_cfg_regs.sv
module bias_cfg_regs
  import bias_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_ramp,
  input  logic       cfg_pd,
  input  logic       rej_rd,
  input  logic       lock,
  output logic [1:0] ramp_q,
  output logic       pd_q,
  output logic       rej_q
);

  logic ramp_load;
  logic wr_blocked;

  assign ramp_load  = cfg_wr && !lock;
  assign wr_blocked = cfg_wr && lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= RAMP_RESET;
      pd_q   <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      if (ramp_load) ramp_q <= cfg_ramp;
      if (cfg_wr)    pd_q   <= cfg_pd;
      if (wr_blocked)  rej_q <= 1'b1;
      else if (rej_rd) rej_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bias_delay_ctr.sv
module bias_delay_ctr
  import bias_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned CNT_W        = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_req,
  input  logic       tick_en,
  input  logic [1:0] ramp_code,
  output logic       busy,
  output logic       valid
);

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   limit;
  logic               count_done;

  assign limit      = CNT_W'(ramp_ms(ramp_code) * TICKS_PER_MS);
  assign count_done = (state == ST_RAMP) && tick_en && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!pwr_req) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_RAMP;
          cnt   <= '0;
        end
        ST_RAMP: begin
          if (count_done)   state <= ST_DONE;
          else if (tick_en) cnt   <= cnt + 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign busy  = (state == ST_RAMP);
  assign valid = (state == ST_DONE);

endmodule

// File: rtl/bias_seq_top.sv
module bias_seq_top
  import bias_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  localparam int unsigned CNT_W = $clog2(MAX_MS * TICKS_PER_MS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       pwr_req,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_ramp,
  input  logic       cfg_pd,
  input  logic       rej_rd,
  output logic [1:0] ramp_code,
  output logic       pd_on,
  output logic       busy,
  output logic       status_valid,
  output logic       wr_rejected
);

  logic ramp_lock;

  assign ramp_lock = busy;

  bias_cfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_ramp (cfg_ramp),
    .cfg_pd   (cfg_pd),
    .rej_rd   (rej_rd),
    .lock     (ramp_lock),
    .ramp_q   (ramp_code),
    .pd_q     (pd_on),
    .rej_q    (wr_rejected)
  );

  bias_delay_ctr #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .CNT_W        (CNT_W)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .pwr_req   (pwr_req),
    .tick_en   (tick_en),
    .ramp_code (ramp_code),
    .busy      (busy),
    .valid     (status_valid)
  );

endmodule

// File: rtl/bias_seq_chk.sv
module bias_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_req,
  input logic       cfg_wr,
  input logic       rej_rd,
  input logic [1:0] ramp_code,
  input logic       busy,
  input logic       status_valid,
  input logic       wr_rejected,
  input logic       ramp_lock
);

  a_r6_code_locked: assert property (@(posedge clk) disable iff (rst)
    ramp_lock |=> $stable(ramp_code));

  a_r6_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (ramp_lock && cfg_wr) |=> wr_rejected);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rej_rd && !(cfg_wr && ramp_lock)) |=> !wr_rejected);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && status_valid));

  a_r8_valid_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(status_valid) |-> $past(busy));

  a_r9_drop_cancels: assert property (@(posedge clk) disable iff (rst)
    !pwr_req |=> (!busy && !status_valid));

endmodule

bind bias_seq_top bias_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_req      (pwr_req),
  .cfg_wr       (cfg_wr),
  .rej_rd       (rej_rd),
  .ramp_code    (ramp_code),
  .busy         (busy),
  .status_valid (status_valid),
  .wr_rejected  (wr_rejected),
  .ramp_lock    (ramp_lock)
);

// File: tb/sim_bias_seq_top.sv
`timescale 1ns/1ps
module sim_bias_seq_top;

  localparam int TPM = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, pwr_req = 1'b0, cfg_wr = 1'b0, cfg_pd = 1'b0, rej_rd = 1'b0;
  logic [1:0] cfg_ramp = 2'b00;
  logic [1:0] ramp_code;
  logic pd_on, busy, status_valid, wr_rejected;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bias_seq_top #(.TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pwr_req(pwr_req),
    .cfg_wr(cfg_wr), .cfg_ramp(cfg_ramp), .cfg_pd(cfg_pd), .rej_rd(rej_rd),
    .ramp_code(ramp_code), .pd_on(pd_on), .busy(busy),
    .status_valid(status_valid), .wr_rejected(wr_rejected)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic int exp_delay(input int code);
    int ms[4] = '{10, 40, 90, 170};
    return ms[code] * TPM;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] r, input logic p, input logic rd = 1'b0);
    cfg_wr = 1'b1; cfg_ramp = r; cfg_pd = p; rej_rd = rd;
    step();
    cfg_wr = 1'b0; rej_rd = 1'b0;
  endtask

  task automatic rd_flag();
    rej_rd = 1'b1;
    step();
    rej_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(3); rst = 1'b0;
  endtask

  initial begin
    int n;
    int ticks;
    step();
    do_reset();
    // R1 reset values
    chk("R1 ramp", ramp_code, 2);
    chk("R1 pd", pd_on, 0);
    chk("R1 busy", busy, 0);
    chk("R1 valid", status_valid, 0);
    chk("R1 rej", wr_rejected, 0);

    // R2 pulldown write in idle
    wr(2'b10, 1'b1);
    chk("R2 pd on", pd_on, 1);
    wr(2'b10, 1'b0);
    chk("R2 pd off", pd_on, 0);

    // R3/R4/R8/R9 sweep all codes, tick every cycle
    tick_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr(2'(c), 1'b0);
      chk("R3 code load", ramp_code, c);
      pwr_req = 1'b1;
      step();
      n = 0;
      while (busy && n < 1000) begin
        chk("R8 no valid while busy", status_valid, 0);
        n++;
        step();
      end
      chk("R4 delay length", n, exp_delay(c));
      chk("R8 valid after ramp", status_valid, 1);
      step(3);
      chk("R8 valid held", status_valid, 1);
      pwr_req = 1'b0;
      step();
      chk("R9 busy after drop", busy, 0);
      chk("R9 valid after drop", status_valid, 0);
    end

    // R5 sparse tick: code 01, tick every third cycle
    wr(2'b01, 1'b0);
    tick_en = 1'b0;
    pwr_req = 1'b1;
    step();
    n = 0; ticks = 0;
    while (busy && n < 5000) begin
      tick_en = (n % 3 == 0);
      if (tick_en) ticks++;
      n++;
      step();
    end
    tick_en = 1'b1;
    chk("R5 ticks consumed", ticks, exp_delay(1));
    chk("R5 cycles stretched", (n >= 3 * exp_delay(1) - 2) ? 1 : 0, 1);
    pwr_req = 1'b0;
    step();

    // R6/R7 lock window collision at slow code
    wr(2'b10, 1'b0);
    pwr_req = 1'b1;
    step(5);
    chk("R6 busy mid ramp", busy, 1);
    wr(2'b01, 1'b1);
    chk("R6 code kept", ramp_code, 2);
    chk("R6 flag set", wr_rejected, 1);
    chk("R2 pd while busy", pd_on, 1);
    rd_flag();
    chk("R7 read clears", wr_rejected, 0);
    wr(2'b11, 1'b0, 1'b1);
    chk("R7 set wins", wr_rejected, 1);
    chk("R6 code kept again", ramp_code, 2);
    chk("R2 pd cleared while busy", pd_on, 0);
    rd_flag();
    chk("R7 cleared", wr_rejected, 0);

    // R9 cancel mid ramp releases lock
    pwr_req = 1'b0;
    step();
    chk("R9 cancel busy", busy, 0);
    wr(2'b11, 1'b0);
    chk("R9 lock released", ramp_code, 3);
    chk("R9 no reject", wr_rejected, 0);

    // R10 reset during ramp
    wr(2'b00, 1'b1);
    pwr_req = 1'b1;
    step(4);
    wr(2'b01, 1'b1);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R10 ramp", ramp_code, 2);
    chk("R10 pd", pd_on, 0);
    chk("R10 rej", wr_rejected, 0);
    pwr_req = 1'b0;
    rst = 1'b1; step(); rst = 1'b0;
    chk("R10 busy", busy, 0);
    chk("R10 valid", status_valid, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule